// File: doc/BRIEF.md
# Address-Event Link Receiver

This block terminates the receive end of an asynchronous address-event link. A sender announces an event by pulling an active-low request line, drives a node address onto a bus, and raises a data-valid bit once that address has settled. The receiver brings these three inputs into its own clock domain and checks data-valid before it trusts the address. It then turns a valid, non-null address into a single-clock one-hot strobe toward one of the target nodes and raises acknowledge back to the sender.

Acknowledge is raised only by a successful decode. It stays high after the sender removes the address and data-valid, and it drops only once the sender has released its request. This closes the four-phase exchange, and the next event can then start. An address of all zeros means that no node is selected. It never produces a strobe or an acknowledge. If data-valid is high while no request is active, the block flags a protocol error.

Top module: `evt_link_rx`

## Requirements
- R1: After reset, `evt_ack`, every bit of `node_strobe` and `proto_err` are low.
- R2: An address is taken only after data-valid has been seen high for `QUAL_CYCLES` (default 2) consecutive synchronized clocks while request is active. A shorter data-valid pulse, and any address value present while data-valid is low, produce no strobe.
- R3: An accepted address A sets only bit A of `node_strobe`, for exactly one clock per event, even if data-valid stays high much longer.
- R4: `evt_ack` rises in the same clock as the strobe of the accepted event.
- R5: Address 0 is null. It produces no strobe and no acknowledge.
- R6: Once high, `evt_ack` stays high while request remains active, even after data-valid and the address are removed or changed.
- R7: `evt_ack` falls only after `evt_req_n` has returned high for at least `SYNC_STAGES` clocks. After that fall, a new event is accepted.
- R8: `proto_err` is high while synchronized data-valid is high and synchronized request is inactive. No strobe is produced then.
- R9: While `evt_ack` is high, no further strobe is produced. This holds even if data-valid pulses again with a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_req_n | input | 1 | Sender request, active low, asynchronous |
| evt_valid | input | 1 | Address-settled qualifier, asynchronous |
| evt_addr | input | ADDR_W | Target node address, asynchronous |
| evt_ack | output | 1 | Acknowledge to sender |
| node_strobe | output | 2**ADDR_W | One-hot single-clock stimulus per target node |
| proto_err | output | 1 | Data-valid seen without an active request |

## Verification
The assertions assume that the sender follows the four-phase order. The address is steady before data-valid rises and stays steady while data-valid is high. Data-valid falls before request is released. Request is not reasserted until acknowledge has dropped. The stimulus changes inputs only on falling clock edges. It sets the address one clock before raising data-valid, and it waits out the synchronizer delay before each following phase. The protocol-error case and the short data-valid pulse are the only steps that break this order, and they do so on purpose.

// File: rtl/evt_link_rx_pkg.sv
package evt_link_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_ACKED = 2'd1,
      RX_NULL  = 2'd2
   } rx_state_e;
endpackage

// File: rtl/evt_rx_sync.sv
module evt_rx_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[0] <= '0;
      else         chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[s] <= '0;
         else         chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_rx_decode.sv
module evt_rx_decode #(
   parameter int ADDR_W = 6,
   localparam int NODES = 2 ** ADDR_W
) (
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NODES-1:0]  line_o,
   output logic              hit_o
);
   // node 0 is the null address and never gets a line
   assign line_o[0] = 1'b0;

   for (genvar n = 1; n < NODES; n++) begin : g_line
      assign line_o[n] = en_i && (addr_i == ADDR_W'(n));
   end

   // wired-OR of all decoded lines drives the acknowledge request
   assign hit_o = |line_o;
endmodule

// File: rtl/evt_rx_seq.sv
module evt_rx_seq
   import evt_link_rx_pkg::*;
#(
   parameter int NODES       = 64,
   parameter int QUAL_CYCLES = 2,
   localparam int CW         = $clog2(QUAL_CYCLES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_s_i,
   input  logic             valid_s_i,
   input  logic             hit_i,
   input  logic [NODES-1:0] line_i,
   output logic             take_o,
   output logic             ack_o,
   output logic [NODES-1:0] strobe_o,
   output logic             err_o
);
   rx_state_e     st_q;
   logic [CW-1:0] qual_q;
   logic          qual_done;
   logic          busy_req;

   assign busy_req  = req_s_i && valid_s_i;
   assign qual_done = (qual_q == CW'(QUAL_CYCLES - 1));
   assign take_o    = (st_q == RX_IDLE) && busy_req && qual_done;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= RX_IDLE;
         qual_q   <= '0;
         ack_o    <= 1'b0;
         strobe_o <= '0;
         err_o    <= 1'b0;
      end else begin
         strobe_o <= '0;
         err_o    <= valid_s_i && !req_s_i;
         unique case (st_q)
            RX_IDLE: begin
               if (busy_req) begin
                  if (qual_done) begin
                     qual_q <= '0;
                     if (hit_i) begin
                        st_q     <= RX_ACKED;
                        ack_o    <= 1'b1;
                        strobe_o <= line_i;
                     end else begin
                        st_q <= RX_NULL;
                     end
                  end else begin
                     qual_q <= qual_q + 1'b1;
                  end
               end else begin
                  qual_q <= '0;
               end
            end
            RX_ACKED: begin
               if (!req_s_i) begin
                  st_q  <= RX_IDLE;
                  ack_o <= 1'b0;
               end
            end
            RX_NULL: begin
               if (!valid_s_i || !req_s_i) st_q <= RX_IDLE;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/evt_link_rx.sv
module evt_link_rx #(
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYCLES = 2,
   localparam int NODES      = 2 ** ADDR_W,
   localparam int SW         = ADDR_W + 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              evt_req_n,
   input  logic              evt_valid,
   input  logic [ADDR_W-1:0] evt_addr,
   output logic              evt_ack,
   output logic [NODES-1:0]  node_strobe,
   output logic              proto_err
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("evt_link_rx: ADDR_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evt_link_rx: SYNC_STAGES must be at least 2");
   end
   if (QUAL_CYCLES < 1 || QUAL_CYCLES > 15) begin : g_bad_qual
      $error("evt_link_rx: QUAL_CYCLES out of range");
   end

   logic [SW-1:0]     raw_bus, sync_bus;
   logic              req_s, valid_s;
   logic [ADDR_W-1:0] addr_s;
   logic              take, hit;
   logic [NODES-1:0]  lines;

   // request is inverted to active-high before it crosses
   assign raw_bus = {~evt_req_n, evt_valid, evt_addr};

   evt_rx_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_bus),
      .q_o    (sync_bus)
   );

   assign req_s   = sync_bus[SW-1];
   assign valid_s = sync_bus[SW-2];
   assign addr_s  = sync_bus[ADDR_W-1:0];

   evt_rx_decode #(.ADDR_W(ADDR_W)) u_dec (
      .en_i   (take),
      .addr_i (addr_s),
      .line_o (lines),
      .hit_o  (hit)
   );

   evt_rx_seq #(.NODES(NODES), .QUAL_CYCLES(QUAL_CYCLES)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_s_i   (req_s),
      .valid_s_i (valid_s),
      .hit_i     (hit),
      .line_i    (lines),
      .take_o    (take),
      .ack_o     (evt_ack),
      .strobe_o  (node_strobe),
      .err_o     (proto_err)
   );
endmodule

// File: rtl/evt_link_rx_chk.sv
module evt_link_rx_chk #(
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   localparam int NODES      = 2 ** ADDR_W
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             evt_req_n,
   input logic             evt_ack,
   input logic [NODES-1:0] node_strobe,
   input logic             proto_err
);
   logic [7:0] idle_run_q;

   // consecutive clocks with the request released, saturating
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             idle_run_q <= '0;
      else if (!evt_req_n)     idle_run_q <= '0;
      else if (idle_run_q != 8'hFF) idle_run_q <= idle_run_q + 8'd1;
   end

   p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(node_strobe));

   p_single_clock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|node_strobe) |=> !(|node_strobe));

   p_ack_with_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_ack) |-> (|node_strobe));

   p_null_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !node_strobe[0]);

   p_ack_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(evt_ack) |-> (idle_run_q >= 8'(SYNC_STAGES)));

   p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_ack && !evt_req_n) |=> evt_ack);

   p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proto_err |-> !(|node_strobe));

   p_one_per_handshake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|node_strobe) |-> !$past(evt_ack));
endmodule

bind evt_link_rx evt_link_rx_chk #(
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .evt_req_n   (evt_req_n),
   .evt_ack     (evt_ack),
   .node_strobe (node_strobe),
   .proto_err   (proto_err)
);

// File: tb/sim_evt_link_rx.sv
module sim_evt_link_rx;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 6;
   localparam int NN         = 2 ** AW;
   localparam int WAITC      = 10;
   localparam int NVEC       = 7;
   // fields: valid(1) addr(6) expected pulses(1) expected ack(1)
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b1, 6'd5,  1'b1, 1'b1},
      {1'b1, 6'd0,  1'b0, 1'b0},
      {1'b1, 6'd63, 1'b1, 1'b1},
      {1'b0, 6'd12, 1'b0, 1'b0},
      {1'b1, 6'd1,  1'b1, 1'b1},
      {1'b1, 6'd32, 1'b1, 1'b1},
      {1'b1, 6'd42, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_n = 1'b1;
   logic          valid = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ack;
   logic [NN-1:0] strobe;
   logic          err;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_link_rx u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .evt_req_n   (req_n),
      .evt_valid   (valid),
      .evt_addr    (addr),
      .evt_ack     (ack),
      .node_strobe (strobe),
      .proto_err   (err)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // advance n falling edges, counting strobe cycles and recording the last seen
   task automatic watch(input int n, output int pulses, output logic [NN-1:0] seen);
      pulses = 0;
      seen = '0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (|strobe) begin
            pulses++;
            seen = strobe;
         end
      end
   endtask

   task automatic release_req();
      int p;
      logic [NN-1:0] s;
      @(negedge clk);
      valid = 1'b0;
      watch(4, p, s);
      req_n = 1'b1;
      watch(WAITC, p, s);
   endtask

   initial begin
      int p;
      logic [NN-1:0] s;
      repeat (3) @(negedge clk);
      check(ack == 1'b0 && strobe == '0 && err == 1'b0, "R1 reset", {ack, err}, 0);
      rst_n = 1'b1;
      watch(3, p, s);
      check(ack == 1'b0 && p == 0 && err == 1'b0, "R1 after reset", p, 0);

      for (int v = 0; v < NVEC; v++) begin
         logic          dv;
         logic [AW-1:0] a;
         logic          ep, ea;
         {dv, a, ep, ea} = VEC[v];
         @(negedge clk);
         addr = a;
         req_n = 1'b0;
         @(negedge clk);
         valid = dv;
         watch(WAITC, p, s);
         check(p == int'(ep), "R2/R3/R5 pulse count", p, ep);
         if (ep) check(s == (NN'(1) << a), "R3 one-hot index", s, NN'(1) << a);
         check(ack == ea, "R4/R5 ack", ack, ea);
         valid = 1'b0;
         addr = ~a;
         watch(WAITC, p, s);
         check(ack == ea && p == 0, "R6 ack held", ack, ea);
         req_n = 1'b1;
         watch(WAITC, p, s);
         check(ack == 1'b0 && p == 0, "R7 ack released", ack, 0);
      end

      // R2: one-clock valid pulse is too short, addresses while valid low ignored
      @(negedge clk);
      addr = 6'd9;
      req_n = 1'b0;
      @(negedge clk);
      valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      addr = 6'd50;
      watch(WAITC, p, s);
      check(p == 0 && ack == 1'b0, "R2 short valid", p, 0);
      addr = 6'd17;
      @(negedge clk);
      valid = 1'b1;
      watch(WAITC, p, s);
      check(p == 1 && s == (NN'(1) << 17), "R2 address after valid", s, NN'(1) << 17);

      // R9: second valid pulse with new address during ack
      valid = 1'b0;
      watch(4, p, s);
      addr = 6'd3;
      @(negedge clk);
      valid = 1'b1;
      watch(WAITC, p, s);
      check(p == 0 && ack == 1'b1, "R9 no strobe while ack high", p, 0);
      release_req();
      check(ack == 1'b0, "R7 release after R9", ack, 0);

      // R8: valid without request
      @(negedge clk);
      addr = 6'd20;
      valid = 1'b1;
      watch(5, p, s);
      check(err == 1'b1, "R8 error flagged", err, 1);
      check(p == 0 && ack == 1'b0, "R8 no strobe", p, 0);
      valid = 1'b0;
      watch(5, p, s);
      check(err == 1'b0, "R8 error clears", err, 0);

      // R7: fresh event after a completed handshake
      @(negedge clk);
      addr = 6'd40;
      req_n = 1'b0;
      @(negedge clk);
      valid = 1'b1;
      watch(WAITC, p, s);
      check(p == 1 && s == (NN'(1) << 40) && ack == 1'b1, "R7 next event", s, NN'(1) << 40);
      release_req();
      check(ack == 1'b0, "R7 final release", ack, 0);

      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      finish_run();
   end
endmodule